// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

This block turns a software request for an interprocessor interrupt into a single delivery strobe aimed at a set of interrupt controllers. Software programs a 64-bit command as two 32-bit words through a small memory-mapped register port. The upper word holds only the destination and is stored silently. Writing the lower word launches the request, using the destination already held from the upper word. Message-signalled writes, which carry their routing in the address and their vector in the data, arrive on a second port and share the same dispatch path.

For each launch the block decodes the vector, the delivery mode, the trigger mode, the destination mode and an optional destination shorthand. It then resolves the target set against a table of controller slots. Each slot holds a physical ID, a logical ID bit-set and an occupancy flag. The result is registered and presented for one cycle as a mask with one bit per slot, together with the mode, vector and trigger. Receive-side handling belongs to the controllers themselves.

Top module: `ipi_dispatch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `dlv_valid` is 0. The stored destination word resets to 0.
- R2: The register index is `reg_addr[11:4]`. A write with any address bit above bit 11 set, with index 0, or with any index other than 0x30 and 0x31 produces no strobe and leaves the stored destination unchanged.
- R3: A write to index 0x31 stores the word and produces no strobe. Its bits 31:24 become the destination for later launches.
- R4: A write to index 0x30 produces `dlv_valid` for exactly the next cycle. The strobe carries vector = bits 7:0, mode = bits 10:8 and trigger = bit 15 of the written word. Launches on consecutive cycles give consecutive strobes.
- R5: With bit 11 = 0 (physical) and no shorthand, a slot is present only if it and every lower slot are occupied, so the search stops at the first empty slot. The mask holds the single lowest present slot whose physical ID equals the destination, or no bit when none matches. Destination 0xFF selects every present slot.
- R6: With bit 11 = 1 (logical) and no shorthand, the mask holds every present slot whose logical ID shares at least one set bit with the destination.
- R7: The shorthand in bits 19:18 overrides the destination. 0 = none, 1 = only slot `self_idx`, 2 = all present slots, 3 = all present slots except `self_idx`.
- R8: A message write whose address lies in 0xFEE00000..0xFEEFFFFF produces a strobe in the next cycle. The address supplies the destination (bits 19:12) and the destination mode (bit 2, 1 = logical). The data supplies the vector (bits 7:0), the mode (bits 10:8) and the trigger (bit 15). The redirection hint (address bit 3) and all other bits have no effect, and no shorthand applies.
- R9: A message write outside that window produces no strobe.
- R10: When a lower-word launch and a message write arrive in the same cycle, only the register launch is dispatched and the message write is dropped.
- R11: Message writes never change the stored destination word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register write |
| reg_wdata | input | 32 | Register write data |
| msi_wr_en | input | 1 | Message write strobe |
| msi_addr | input | 32 | Message write address |
| msi_wdata | input | 32 | Message write data |
| self_idx | input | IDX_W | Slot index of the issuing controller |
| ctrl_pid | input | 8*NUM_CTRL | Physical ID of each slot, slot i at bits 8i+7:8i |
| ctrl_lid | input | 8*NUM_CTRL | Logical ID bit-set of each slot |
| ctrl_used | input | NUM_CTRL | Slot occupancy flags |
| dlv_valid | output | 1 | One-cycle delivery strobe |
| dlv_mask | output | NUM_CTRL | Target slots |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Interrupt vector |
| dlv_trigger | output | 1 | Trigger mode, 1 = level |

## Verification
The bench builds the block with NUM_CTRL = 6 and ADDR_W = 16. A six-slot table is small enough to leave slot 4 empty while slot 5 holds a valid ID, so the stop at the first empty slot is visible both in physical matching and in the broadcast masks. The 16-bit register address still has bits above bit 11, so writes beyond offset 0xFFF that alias valid indices can be tried. The message window keeps its default base, so addresses just above and below it test the window edges.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   localparam int unsigned ID_W     = 8;
   localparam int unsigned WORD_W   = 32;
   localparam logic [7:0]  IDX_LO   = 8'h30;
   localparam logic [7:0]  IDX_HI   = 8'h31;
   localparam logic [7:0]  DEST_ALL = 8'hFF;

   typedef enum logic [1:0] {
      SH_NONE   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } ipi_sh_e;

   typedef struct packed {
      logic [ID_W-1:0] dest;
      logic            dmode;
      logic [2:0]      dlvm;
      logic [7:0]      vec;
      logic            trig;
      ipi_sh_e         sh;
   } ipi_req_t;

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
   import ipi_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [WORD_W-1:0]   wdata,
   output logic                launch,
   output ipi_req_t            req
);

   logic [WORD_W-1:0] hi_q;
   logic              in_range;
   logic [7:0]        idx;
   logic              hit;
   logic              unused_bits;

   assign in_range = (addr[ADDR_W-1:12] == '0);
   assign idx      = addr[11:4];
   assign hit      = wr_en && in_range && (idx != 8'h00);
   assign launch   = hit && (idx == IDX_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
      end else if (hit && (idx == IDX_HI)) begin
         hi_q <= wdata;
      end
   end

   always_comb begin
      req.dest  = hi_q[31:24];
      req.dmode = wdata[11];
      req.dlvm  = wdata[10:8];
      req.vec   = wdata[7:0];
      req.trig  = wdata[15];
      req.sh    = ipi_sh_e'(wdata[19:18]);
   end

   assign unused_bits = ^{addr[3:0], hi_q[23:0], wdata[31:20], wdata[17:16], wdata[14:12]};

endmodule

// File: rtl/ipi_msi_decode.sv
module ipi_msi_decode
   import ipi_pkg::*;
#(
   parameter logic [31:0] MSI_BASE     = 32'hFEE0_0000,
   parameter int unsigned MSI_WIN_LOG2 = 20
) (
   input  logic              wr_en,
   input  logic [31:0]       addr,
   input  logic [WORD_W-1:0] wdata,
   output logic              launch,
   output ipi_req_t          req
);

   logic in_win;
   logic unused_bits;

   assign in_win = (addr[31:MSI_WIN_LOG2] == MSI_BASE[31:MSI_WIN_LOG2]);
   assign launch = wr_en && in_win;

   always_comb begin
      req.dest  = addr[19:12];
      req.dmode = addr[2];
      req.dlvm  = wdata[10:8];
      req.vec   = wdata[7:0];
      req.trig  = wdata[15];
      req.sh    = SH_NONE;
   end

   assign unused_bits = ^{addr[11:3], addr[1:0], wdata[31:16], wdata[14:11], MSI_BASE};

endmodule

// File: rtl/ipi_target_mask.sv
module ipi_target_mask
   import ipi_pkg::*;
#(
   parameter int unsigned NUM_CTRL = 8,
   parameter int unsigned IDX_W    = 3
) (
   input  ipi_req_t                   req,
   input  logic [ID_W*NUM_CTRL-1:0]   pid,
   input  logic [ID_W*NUM_CTRL-1:0]   lid,
   input  logic [NUM_CTRL-1:0]        used,
   input  logic [IDX_W-1:0]           self_idx,
   output logic [NUM_CTRL-1:0]        mask
);

   localparam logic [NUM_CTRL-1:0] ONE = NUM_CTRL'(1);

   logic [NUM_CTRL-1:0] present;
   logic [NUM_CTRL-1:0] phys_hit;
   logic [NUM_CTRL-1:0] phys_first;
   logic [NUM_CTRL-1:0] log_hit;
   logic [NUM_CTRL-1:0] self_oh;

   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_slot
      if (i == 0) begin : g_head
         assign present[i] = used[i];
      end else begin : g_tail
         assign present[i] = used[i] && present[i-1];
      end
      assign phys_hit[i] = present[i] && (pid[i*ID_W +: ID_W] == req.dest);
      assign log_hit[i]  = present[i] && ((lid[i*ID_W +: ID_W] & req.dest) != '0);
      assign self_oh[i]  = (self_idx == IDX_W'(i));
   end

   assign phys_first = phys_hit & (~phys_hit + ONE);

   always_comb begin
      unique case (req.sh)
         SH_SELF:   mask = self_oh;
         SH_ALL:    mask = present;
         SH_OTHERS: mask = present & ~self_oh;
         default: begin
            if (req.dmode)                 mask = log_hit;
            else if (req.dest == DEST_ALL) mask = present;
            else                           mask = phys_first;
         end
      endcase
   end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
   import ipi_pkg::*;
#(
   parameter int unsigned NUM_CTRL     = 8,
   parameter int unsigned ADDR_W       = 32,
   parameter logic [31:0] MSI_BASE     = 32'hFEE0_0000,
   parameter int unsigned MSI_WIN_LOG2 = 20,
   localparam int unsigned IDX_W       = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr_en,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [31:0]                reg_wdata,
   input  logic                       msi_wr_en,
   input  logic [31:0]                msi_addr,
   input  logic [31:0]                msi_wdata,
   input  logic [IDX_W-1:0]           self_idx,
   input  logic [8*NUM_CTRL-1:0]      ctrl_pid,
   input  logic [8*NUM_CTRL-1:0]      ctrl_lid,
   input  logic [NUM_CTRL-1:0]        ctrl_used,
   output logic                       dlv_valid,
   output logic [NUM_CTRL-1:0]        dlv_mask,
   output logic [2:0]                 dlv_mode,
   output logic [7:0]                 dlv_vector,
   output logic                       dlv_trigger
);

   if (NUM_CTRL < 1 || NUM_CTRL > 255) begin : g_bad_count
      $error("NUM_CTRL must lie in 1..255");
   end
   if (ADDR_W <= 12) begin : g_bad_addr
      $error("ADDR_W must exceed 12 to detect offsets above 0xFFF");
   end
   if (MSI_WIN_LOG2 < 20 || MSI_WIN_LOG2 > 31) begin : g_bad_win
      $error("MSI_WIN_LOG2 must lie in 20..31 to keep the destination field inside the window");
   end

   logic                reg_go, msi_go;
   ipi_req_t            reg_req, msi_req, sel_req;
   logic [NUM_CTRL-1:0] sel_mask;

   ipi_cmd_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr_en),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .launch (reg_go),
      .req    (reg_req)
   );

   ipi_msi_decode #(.MSI_BASE(MSI_BASE), .MSI_WIN_LOG2(MSI_WIN_LOG2)) msi_i (
      .wr_en  (msi_wr_en),
      .addr   (msi_addr),
      .wdata  (msi_wdata),
      .launch (msi_go),
      .req    (msi_req)
   );

   assign sel_req = reg_go ? reg_req : msi_req;

   ipi_target_mask #(.NUM_CTRL(NUM_CTRL), .IDX_W(IDX_W)) tgt_i (
      .req      (sel_req),
      .pid      (ctrl_pid),
      .lid      (ctrl_lid),
      .used     (ctrl_used),
      .self_idx (self_idx),
      .mask     (sel_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dlv_valid   <= 1'b0;
         dlv_mask    <= '0;
         dlv_mode    <= '0;
         dlv_vector  <= '0;
         dlv_trigger <= 1'b0;
      end else begin
         dlv_valid <= reg_go || msi_go;
         if (reg_go || msi_go) begin
            dlv_mask    <= sel_mask;
            dlv_mode    <= sel_req.dlvm;
            dlv_vector  <= sel_req.vec;
            dlv_trigger <= sel_req.trig;
         end
      end
   end

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
   parameter int unsigned NUM_CTRL     = 8,
   parameter int unsigned ADDR_W       = 32,
   parameter logic [31:0] MSI_BASE     = 32'hFEE0_0000,
   parameter int unsigned MSI_WIN_LOG2 = 20,
   localparam int unsigned IDX_W       = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr_en,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [31:0]           reg_wdata,
   input logic                  msi_wr_en,
   input logic [31:0]           msi_addr,
   input logic [31:0]           msi_wdata,
   input logic [IDX_W-1:0]      self_idx,
   input logic                  dlv_valid,
   input logic [NUM_CTRL-1:0]   dlv_mask,
   input logic [2:0]            dlv_mode,
   input logic [7:0]            dlv_vector,
   input logic                  dlv_trigger
);

   localparam logic [NUM_CTRL-1:0] ONE = NUM_CTRL'(1);

   logic lo_go, msi_in, msi_only;
   assign lo_go    = reg_wr_en && (reg_addr[ADDR_W-1:12] == '0) && (reg_addr[11:4] == 8'h30);
   assign msi_in   = msi_addr[31:MSI_WIN_LOG2] == MSI_BASE[31:MSI_WIN_LOG2];
   assign msi_only = !reg_wr_en && msi_wr_en;

   // R4: a lower-word write yields a strobe carrying its fields
   a_r4_lo_launch: assert property (@(posedge clk) disable iff (!rst_n)
      lo_go |=> dlv_valid && dlv_vector == $past(reg_wdata[7:0])
                && dlv_mode == $past(reg_wdata[10:8]) && dlv_trigger == $past(reg_wdata[15]));

   // R2: no write of any kind, no strobe
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_en && !msi_wr_en) |=> !dlv_valid);

   // R9: a message write outside the window is dropped
   a_r9_msi_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_only && !msi_in) |=> !dlv_valid);

   // R8: a message write inside the window is dispatched with its data fields
   a_r8_msi_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_only && msi_in) |=> dlv_valid && dlv_vector == $past(msi_wdata[7:0])
                               && dlv_trigger == $past(msi_wdata[15]));

   // R5: a physical non-broadcast destination selects at most one slot
   a_r5_phys_single: assert property (@(posedge clk) disable iff (!rst_n)
      (msi_only && msi_in && !msi_addr[2] && msi_addr[19:12] != 8'hFF) |=> $onehot0(dlv_mask));

   // R7: self shorthand targets exactly the issuing slot
   a_r7_self_only: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_go && reg_wdata[19:18] == 2'b01) |=> dlv_mask == (ONE << $past(self_idx)));

endmodule

bind ipi_dispatch ipi_dispatch_chk #(
   .NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W), .MSI_BASE(MSI_BASE), .MSI_WIN_LOG2(MSI_WIN_LOG2)
) chk_i (.*);

// File: tb/ipi_dispatch_tb_top.sv
module ipi_dispatch_tb_top;

   localparam int unsigned N    = 6;
   localparam int unsigned AW   = 16;
   localparam int unsigned SELF = 2;
   localparam logic [8*N-1:0] PIDS = {8'h15, 8'h14, 8'h13, 8'h12, 8'h11, 8'h10};
   localparam logic [8*N-1:0] LIDS = {8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01};
   localparam logic [N-1:0]   USED = 6'b101111;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          msi_wr_en = 1'b0;
   logic [31:0]   msi_addr = '0;
   logic [31:0]   msi_wdata = '0;
   logic          dlv_valid;
   logic [N-1:0]  dlv_mask;
   logic [2:0]    dlv_mode;
   logic [7:0]    dlv_vector;
   logic          dlv_trigger;

   always #4 clk = ~clk;

   ipi_dispatch #(.NUM_CTRL(N), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .msi_wr_en(msi_wr_en), .msi_addr(msi_addr), .msi_wdata(msi_wdata),
      .self_idx(3'(SELF)), .ctrl_pid(PIDS), .ctrl_lid(LIDS), .ctrl_used(USED),
      .dlv_valid(dlv_valid), .dlv_mask(dlv_mask), .dlv_mode(dlv_mode),
      .dlv_vector(dlv_vector), .dlv_trigger(dlv_trigger)
   );

   typedef struct packed {
      logic [N-1:0] mask;
      logic [2:0]   mode;
      logic [7:0]   vec;
      logic         trig;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   function automatic logic [N-1:0] exp_mask(logic [7:0] d, logic dm, logic [1:0] sh);
      logic [N-1:0] m = '0;
      logic [N-1:0] pres = '0;
      bit gap = 1'b0;
      bit found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!USED[i]) gap = 1'b1;
         pres[i] = !gap;
      end
      case (sh)
         2'd1: m[SELF] = 1'b1;
         2'd2: m = pres;
         2'd3: begin m = pres; m[SELF] = 1'b0; end
         default: begin
            if (dm) begin
               for (int i = 0; i < N; i++)
                  if (pres[i] && ((LIDS[i*8 +: 8] & d) != 8'h00)) m[i] = 1'b1;
            end else if (d == 8'hFF) begin
               m = pres;
            end else begin
               for (int i = 0; i < N; i++)
                  if (!found && pres[i] && PIDS[i*8 +: 8] == d) begin
                     m[i] = 1'b1;
                     found = 1'b1;
                  end
            end
         end
      endcase
      return m;
   endfunction

   function automatic logic [31:0] mk_lo(logic [7:0] vec, logic [2:0] md, logic dm,
                                         logic trig, logic [1:0] sh);
      return {12'h000, sh, 2'b00, trig, 3'b000, dm, md, vec};
   endfunction

   function automatic logic [31:0] mk_msi(logic [7:0] vec, logic [2:0] md, logic trig);
      return {16'h0000, trig, 4'h0, md, vec};
   endfunction

   task automatic push(logic [N-1:0] m, logic [2:0] md, logic [7:0] v, logic t, string tag);
      exp_t e;
      e.mask = m; e.mode = md; e.vec = v; e.trig = t;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic reg_wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic msi_wr(logic [31:0] a, logic [31:0] d);
      @(negedge clk);
      msi_wr_en = 1'b1; msi_addr = a; msi_wdata = d;
      @(negedge clk);
      msi_wr_en = 1'b0;
   endtask

   task automatic reg_launch(logic [7:0] dest, logic [31:0] lo, string tag);
      push(exp_mask(dest, lo[11], lo[19:18]), lo[10:8], lo[7:0], lo[15], tag);
      reg_wr(16'h0300, lo);
   endtask

   task automatic msi_launch(logic [31:0] a, logic [31:0] d, string tag);
      push(exp_mask(a[19:12], a[2], 2'd0), d[10:8], d[7:0], d[15], tag);
      msi_wr(a, d);
   endtask

   task automatic quiet(string tag);
      n_chk++;
      if (dlv_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL %s: dlv_valid actual %b expected 0", tag, dlv_valid);
      end
   endtask

   // monitor: pops expected items as strobes appear
   always @(negedge clk) begin
      if (rst_n && dlv_valid === 1'b1) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected strobe: actual mask %b vec %h expected none", dlv_mask, dlv_vector);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (dlv_mask !== e.mask || dlv_mode !== e.mode || dlv_vector !== e.vec
                || dlv_trigger !== e.trig) begin
               n_bad++;
               $display("FAIL %s: actual mask %b mode %0d vec %h trig %b expected mask %b mode %0d vec %h trig %b",
                        t, dlv_mask, dlv_mode, dlv_vector, dlv_trigger,
                        e.mask, e.mode, e.vec, e.trig);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      quiet("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      quiet("R1 after release");

      // R3: store destination without dispatch
      reg_wr(16'h0310, 32'h1200_0000);
      quiet("R3 high-word write");
      reg_launch(8'h12, mk_lo(8'h41, 3'd0, 1'b0, 1'b0, 2'd0), "R4 physical launch");
      reg_launch(8'h12, mk_lo(8'hFE, 3'd4, 1'b0, 1'b1, 2'd0), "R4 mode and trigger");

      // R5: slot 5 sits beyond the empty slot 4
      reg_wr(16'h0310, 32'h1500_0000);
      reg_launch(8'h15, mk_lo(8'h22, 3'd0, 1'b0, 1'b0, 2'd0), "R5 search stops at empty slot");
      reg_wr(16'h0310, 32'hFF00_0000);
      reg_launch(8'hFF, mk_lo(8'h23, 3'd0, 1'b0, 1'b0, 2'd0), "R5 physical broadcast");

      // R6: logical destination
      reg_wr(16'h0310, 32'h0600_0000);
      reg_launch(8'h06, mk_lo(8'h30, 3'd1, 1'b1, 1'b0, 2'd0), "R6 logical set");
      reg_wr(16'h0310, 32'h3000_0000);
      reg_launch(8'h30, mk_lo(8'h31, 3'd1, 1'b1, 1'b0, 2'd0), "R6 logical beyond empty slot");

      // R7: shorthands override destination 0x30
      reg_launch(8'h30, mk_lo(8'h51, 3'd0, 1'b0, 1'b0, 2'd1), "R7 self");
      reg_launch(8'h30, mk_lo(8'h52, 3'd0, 1'b0, 1'b0, 2'd2), "R7 all including self");
      reg_launch(8'h30, mk_lo(8'h53, 3'd0, 1'b1, 1'b0, 2'd3), "R7 all excluding self");

      // R2: ignored writes
      reg_wr(16'h0310, 32'h1000_0000);
      reg_wr(16'h1310, 32'h1100_0000);
      quiet("R2 high index above 0xFFF");
      reg_wr(16'h1300, mk_lo(8'h60, 3'd0, 1'b0, 1'b0, 2'd0));
      quiet("R2 low index above 0xFFF");
      reg_wr(16'h0008, 32'h1300_0000);
      quiet("R2 index 0");
      reg_wr(16'h0320, 32'h1300_0000);
      quiet("R2 unrelated index");
      reg_launch(8'h10, mk_lo(8'h61, 3'd0, 1'b0, 1'b0, 2'd0), "R2 destination unchanged");

      // R8: message writes
      msi_launch(32'hFEE1_3000, mk_msi(8'h55, 3'd1, 1'b1), "R8 message physical");
      msi_launch(32'hFEE1_3008, mk_msi(8'h56, 3'd2, 1'b0), "R8 redirection hint ignored");
      msi_launch(32'hFEE0_1004, mk_msi(8'h57, 3'd0, 1'b0), "R8 message logical");
      msi_launch(32'hFEEF_F000, mk_msi(8'h58, 3'd0, 1'b0), "R8 window top");

      // R9: outside window
      msi_wr(32'hFEF1_3000, mk_msi(8'h59, 3'd0, 1'b0));
      quiet("R9 above window");
      msi_wr(32'hFEDF_F000, mk_msi(8'h5A, 3'd0, 1'b0));
      quiet("R9 below window");

      // R11: stored destination untouched by message writes
      reg_launch(8'h10, mk_lo(8'h62, 3'd0, 1'b0, 1'b0, 2'd0), "R11 destination kept");

      // R10: simultaneous sources
      push(exp_mask(8'h10, 1'b0, 2'd0), 3'd3, 8'hA1, 1'b1, "R10 register wins");
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = 16'h0300; reg_wdata = mk_lo(8'hA1, 3'd3, 1'b0, 1'b1, 2'd0);
      msi_wr_en = 1'b1; msi_addr = 32'hFEE1_3000; msi_wdata = mk_msi(8'h77, 3'd1, 1'b0);
      @(negedge clk);
      reg_wr_en = 1'b0; msi_wr_en = 1'b0;
      @(negedge clk);
      quiet("R10 message dropped");

      // R4: back-to-back launches
      push(exp_mask(8'h10, 1'b0, 2'd0), 3'd0, 8'hB1, 1'b0, "R4 back-to-back first");
      push(exp_mask(8'h10, 1'b0, 2'd2), 3'd5, 8'hB2, 1'b1, "R4 back-to-back second");
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = 16'h0300; reg_wdata = mk_lo(8'hB1, 3'd0, 1'b0, 1'b0, 2'd0);
      @(negedge clk);
      reg_wdata = mk_lo(8'hB2, 3'd5, 1'b0, 1'b1, 2'd2);
      @(negedge clk);
      reg_wr_en = 1'b0;
      @(negedge clk);
      quiet("R4 strobe lasts one cycle");

      repeat (3) @(negedge clk);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R4 pending strobes: actual %0d outstanding expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule